// File: doc/BRIEF.md
# Half-Precision to Integer Lane Converter

This block turns a vector of half-precision floating-point lanes into 8-bit or 16-bit integers, signed or unsigned, in one clocked stage. Each lane is first rounded to an integer under one of five rounding rules. The rounded value is then fitted to the chosen destination type. In saturating mode it is clamped to that type's range. In non-saturating mode only its low bits are kept. Infinities and NaN get fixed results in both modes.

The saturate decision comes from one of two places. The first is a flag that travels with each conversion. The second is a bit in a wide global control word. A separate enable bit in that same word picks which of the two applies. Each lane has its own enable bit, and a disabled lane writes zero. The output is registered, so the result appears one clock after the inputs are presented.

Top module: `h2i_conv`

## Requirements
- R1: The lane outputs are registered. A result appears on `dst_lanes` at the first rising clock edge after its inputs are applied. While `rst_n` is low, every output bit is 0.
- R2: A lane whose `lane_en` bit is 0 outputs 0, whatever its source value.
- R3: Rounding code 0 rounds to the nearest integer, and ties go to the even neighbour. For example, 2.5 gives 2, 3.5 gives 4, -2.5 gives -2 and 0.5 gives 0.
- R4: Rounding code 1 rounds to the nearest integer, and ties go away from zero. For example, 2.5 gives 3, -2.5 gives -3 and 0.5 gives 1.
- R5: Rounding code 2 rounds toward minus infinity and code 3 rounds toward plus infinity. This holds for subnormal inputs too. For example, -1.5 gives -2 under code 2 and -1 under code 3. The smallest positive subnormal gives 1 under code 3, and its negative gives -1 under code 2.
- R6: Rounding code 4 truncates toward zero, and codes 5 to 7 behave the same as code 4. For example, 2.75 gives 2 and -2.75 gives -2.
- R7: In non-saturating mode, a finite result is reduced to the destination width by keeping its least significant bits, in two's complement. For example, 257 to uint8 gives 1, 300 to int8 gives 44, -1 to uint8 gives 255, -200 to int8 gives 56, and 65504 to uint16 gives 65504.
- R8: In saturating mode, a finite result outside the destination range is clamped to the nearest extreme. For example, 257 to uint8 gives 255, 200 to int8 gives 127, -200 to int8 gives -128, 65504 to int16 gives 32767, and -5 to uint16 gives 0.
- R9: In both modes, plus infinity gives the destination maximum and minus infinity gives the destination minimum. For example, minus infinity gives 0 for uint8 and 0x8000 for int16.
- R10: A NaN input (exponent all ones, mantissa non-zero) gives 0 in both modes.
- R11: When `ctrl_word[60]` is 0, `insn_sat` selects the mode, where 1 means saturating. When `ctrl_word[60]` is 1, `insn_sat` is ignored and `ctrl_word[59]` selects the mode, where 1 means non-saturating and 0 means saturating.
- R12: `dst_kind` selects the destination type: 0 is uint8, 1 is int8, 2 is uint16 and 3 is int16. An 8-bit result sits in bits [7:0] of its 16-bit lane, and bits [15:8] of that lane are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dst_kind | input | 2 | Destination type code |
| insn_sat | input | 1 | Per-conversion saturate flag |
| ctrl_word | input | 64 | Global control word; bits 60 and 59 are used |
| rnd_mode | input | 3 | Rounding code |
| lane_en | input | LANES | Per-lane enable |
| src_lanes | input | 16*LANES | Half-precision source lanes, lane 0 in the low bits |
| dst_lanes | output | 16*LANES | Integer result lanes, lane 0 in the low bits |

## Verification
Every lane has exactly one register between its inputs and its output. Because of that, a fault in rounding, fitting or mode selection shows up on that lane's output one clock after the stimulus. No state carries over from one conversion to the next. A wrong increment decision shows as a result that is off by one on tie or subnormal inputs. A swapped mode select shows as 1 instead of 255 for a value of 257 converted to uint8. A leak past the lane enable or the byte-width rule shows as non-zero bits in a lane or byte that must be clear.

// File: rtl/h2i_pkg.sv
package h2i_pkg;
   localparam int HALF_W = 16;
   localparam int EXP_W  = 5;
   localparam int MAN_W  = 10;
   localparam int BIAS   = 15;
   localparam int SIG_W  = MAN_W + 1;
   // exponent value at which the significand LSB weighs exactly 1
   localparam int POINT  = BIAS + MAN_W;
   localparam int MAG_W  = 17;
   localparam int VAL_W  = MAG_W + 1;
   localparam int OUT_W  = 16;
   localparam int RND_W  = 3;

   typedef enum logic [1:0] {
      K_U8  = 2'd0,
      K_S8  = 2'd1,
      K_U16 = 2'd2,
      K_S16 = 2'd3
   } dst_kind_e;

   typedef enum logic [RND_W-1:0] {
      RM_NEAR_EVEN = 3'd0,
      RM_NEAR_AWAY = 3'd1,
      RM_DOWN      = 3'd2,
      RM_UP        = 3'd3,
      RM_CHOP      = 3'd4
   } rnd_e;

   typedef enum logic [1:0] {
      C_FINITE = 2'd0,
      C_PINF   = 2'd1,
      C_NINF   = 2'd2,
      C_NAN    = 2'd3
   } val_class_e;

   typedef struct packed {
      val_class_e       cls;
      logic             sign;
      logic [MAG_W-1:0] mag;
   } lane_pre_t;
endpackage

// File: rtl/h2i_mode_sel.sv
module h2i_mode_sel #(
   parameter int CTRL_W        = 64,
   parameter int GLB_EN_BIT    = 60,
   parameter int GLB_NOSAT_BIT = 59,
   parameter bit HAS_GLOBAL    = 1'b1
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              insn_sat_i,
   output logic              sat_o
);
   generate
      if (HAS_GLOBAL) begin : g_global
         always_comb begin
            if (ctrl_i[GLB_EN_BIT]) begin
               sat_o = ~ctrl_i[GLB_NOSAT_BIT];
            end else begin
               sat_o = insn_sat_i;
            end
         end
      end else begin : g_local
         logic unused_ctrl;
         assign unused_ctrl = ^ctrl_i;
         assign sat_o = insn_sat_i;
      end
   endgenerate
endmodule

// File: rtl/h2i_unpack_round.sv
module h2i_unpack_round
   import h2i_pkg::*;
(
   input  logic [HALF_W-1:0] half_i,
   input  logic [RND_W-1:0]  rnd_i,
   output lane_pre_t         pre_o
);
   localparam int GRD_W  = POINT - 1;
   localparam int WIDE_W = SIG_W + GRD_W;

   logic [EXP_W-1:0]  exp_f;
   logic [MAN_W-1:0]  man_f;
   logic [EXP_W-1:0]  exp_eff;
   logic [SIG_W-1:0]  sig;
   logic [WIDE_W-1:0] wide;
   logic [SIG_W-1:0]  ipart;
   logic              half_bit;
   logic              sticky;
   logic              inc;

   assign exp_f   = half_i[HALF_W-2 -: EXP_W];
   assign man_f   = half_i[MAN_W-1:0];
   assign exp_eff = (exp_f == '0) ? EXP_W'(1) : exp_f;
   assign sig     = {|exp_f, man_f};

   always_comb begin
      wide     = {sig, GRD_W'(0)} >> (EXP_W'(POINT) - exp_eff);
      ipart    = wide[WIDE_W-1:GRD_W];
      half_bit = wide[GRD_W-1];
      sticky   = |wide[GRD_W-2:0];
      case (rnd_i)
         RM_NEAR_EVEN: inc = half_bit & (sticky | ipart[0]);
         RM_NEAR_AWAY: inc = half_bit;
         RM_DOWN:      inc = half_i[HALF_W-1] & (half_bit | sticky);
         RM_UP:        inc = ~half_i[HALF_W-1] & (half_bit | sticky);
         default:      inc = 1'b0;
      endcase
   end

   always_comb begin
      pre_o      = '0;
      pre_o.sign = half_i[HALF_W-1];
      if (exp_f == '1) begin
         if (man_f != '0) begin
            pre_o.cls = C_NAN;
         end else if (half_i[HALF_W-1]) begin
            pre_o.cls = C_NINF;
         end else begin
            pre_o.cls = C_PINF;
         end
      end else if (exp_eff >= EXP_W'(POINT)) begin
         pre_o.cls = C_FINITE;
         pre_o.mag = MAG_W'(sig) << (exp_eff - EXP_W'(POINT));
      end else begin
         pre_o.cls = C_FINITE;
         pre_o.mag = MAG_W'(ipart) + MAG_W'(inc);
      end
   end
endmodule

// File: rtl/h2i_fit.sv
module h2i_fit
   import h2i_pkg::*;
(
   input  lane_pre_t        pre_i,
   input  logic [1:0]       kind_i,
   input  logic             sat_i,
   output logic [OUT_W-1:0] res_o
);
   logic signed [VAL_W-1:0] val;
   logic signed [VAL_W-1:0] hi;
   logic signed [VAL_W-1:0] lo;
   logic signed [VAL_W-1:0] fitted;

   always_comb begin
      case (dst_kind_e'(kind_i))
         K_U8:    begin hi = 18'sd255;   lo = 18'sd0;      end
         K_S8:    begin hi = 18'sd127;   lo = -18'sd128;   end
         K_U16:   begin hi = 18'sd65535; lo = 18'sd0;      end
         default: begin hi = 18'sd32767; lo = -18'sd32768; end
      endcase
   end

   always_comb begin
      val = pre_i.sign ? -$signed({1'b0, pre_i.mag}) : $signed({1'b0, pre_i.mag});
      case (pre_i.cls)
         C_PINF: fitted = hi;
         C_NINF: fitted = lo;
         C_NAN:  fitted = '0;
         default: begin
            if (sat_i && (val > hi)) begin
               fitted = hi;
            end else if (sat_i && (val < lo)) begin
               fitted = lo;
            end else begin
               fitted = val;
            end
         end
      endcase
   end

   always_comb begin
      if (kind_i[1]) begin
         res_o = fitted[OUT_W-1:0];
      end else begin
         res_o = {{(OUT_W-8){1'b0}}, fitted[7:0]};
      end
   end
endmodule

// File: rtl/h2i_conv.sv
module h2i_conv
   import h2i_pkg::*;
#(
   parameter int LANES         = 4,
   parameter int CTRL_W        = 64,
   parameter int GLB_EN_BIT    = 60,
   parameter int GLB_NOSAT_BIT = 59,
   parameter bit HAS_GLOBAL    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              dst_kind,
   input  logic                    insn_sat,
   input  logic [CTRL_W-1:0]       ctrl_word,
   input  logic [RND_W-1:0]        rnd_mode,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*HALF_W-1:0] src_lanes,
   output logic [LANES*OUT_W-1:0]  dst_lanes
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("h2i_conv: LANES must be at least 1");
      end
      if (GLB_EN_BIT >= CTRL_W || GLB_NOSAT_BIT >= CTRL_W) begin : g_bad_bits
         $error("h2i_conv: control bit positions exceed CTRL_W");
      end
      if (GLB_EN_BIT == GLB_NOSAT_BIT) begin : g_same_bits
         $error("h2i_conv: enable and mode bits must differ");
      end
   endgenerate

   logic sat_eff;

   h2i_mode_sel #(
      .CTRL_W        (CTRL_W),
      .GLB_EN_BIT    (GLB_EN_BIT),
      .GLB_NOSAT_BIT (GLB_NOSAT_BIT),
      .HAS_GLOBAL    (HAS_GLOBAL)
   ) u_mode (
      .ctrl_i     (ctrl_word),
      .insn_sat_i (insn_sat),
      .sat_o      (sat_eff)
   );

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         lane_pre_t        pre;
         logic [OUT_W-1:0] res;
         logic [OUT_W-1:0] q;

         h2i_unpack_round u_rnd (
            .half_i (src_lanes[gi*HALF_W +: HALF_W]),
            .rnd_i  (rnd_mode),
            .pre_o  (pre)
         );

         h2i_fit u_fit (
            .pre_i  (pre),
            .kind_i (dst_kind),
            .sat_i  (sat_eff),
            .res_o  (res)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (lane_en[gi]) begin
               q <= res;
            end else begin
               q <= '0;
            end
         end

         assign dst_lanes[gi*OUT_W +: OUT_W] = q;
      end
   endgenerate
endmodule

// File: rtl/h2i_conv_chk.sv
module h2i_conv_chk
   import h2i_pkg::*;
#(
   parameter int LANES         = 4,
   parameter int CTRL_W        = 64,
   parameter int GLB_EN_BIT    = 60,
   parameter int GLB_NOSAT_BIT = 59,
   parameter bit HAS_GLOBAL    = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              dst_kind,
   input logic                    insn_sat,
   input logic [CTRL_W-1:0]       ctrl_word,
   input logic [RND_W-1:0]        rnd_mode,
   input logic [LANES-1:0]        lane_en,
   input logic [LANES*HALF_W-1:0] src_lanes,
   input logic [LANES*OUT_W-1:0]  dst_lanes
);
   logic glb_sat_sel;
   assign glb_sat_sel = HAS_GLOBAL && ctrl_word[GLB_EN_BIT] && !ctrl_word[GLB_NOSAT_BIT];

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_chk
         logic [HALF_W-1:0] s;
         logic [OUT_W-1:0]  d;
         logic              is_nan;
         assign s      = src_lanes[gi*HALF_W +: HALF_W];
         assign d      = dst_lanes[gi*OUT_W +: OUT_W];
         assign is_nan = (s[14:10] == 5'h1F) && (s[9:0] != '0);

         // R2
         a_r2_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[gi] |=> (d == '0));

         // R10
         a_r10_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en[gi] && is_nan) |=> (d == '0));

         // R12
         a_r12_byte_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !dst_kind[1] |=> (d[15:8] == 8'h00));

         // R9
         a_r9_pinf_s16_max: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en[gi] && s == 16'h7C00 && dst_kind == 2'd3) |=> (d == 16'h7FFF));

         // R8
         a_r8_unsigned_neg_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en[gi] && !dst_kind[0] && s[15] && glb_sat_sel) |=> (d == '0));

         // R11
         a_r11_global_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en[gi] && glb_sat_sel && !insn_sat && dst_kind == 2'd0 && !s[15]
             && s[14:10] >= 5'd23 && s[14:10] != 5'h1F) |=> (d == 16'h00FF));
      end
   endgenerate

   logic unused_rnd;
   assign unused_rnd = ^rnd_mode;
endmodule

bind h2i_conv h2i_conv_chk #(
   .LANES         (LANES),
   .CTRL_W        (CTRL_W),
   .GLB_EN_BIT    (GLB_EN_BIT),
   .GLB_NOSAT_BIT (GLB_NOSAT_BIT),
   .HAS_GLOBAL    (HAS_GLOBAL)
) i_h2i_conv_chk (.*);

// File: tb/test_h2i_conv.sv
`timescale 1ns/1ps
module test_h2i_conv;
   localparam int LANES = 4;
   localparam int NV    = 34;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        dst_kind = '0;
   logic              insn_sat = 1'b0;
   logic [63:0]       ctrl_word = '0;
   logic [2:0]        rnd_mode = '0;
   logic [LANES-1:0]  lane_en = '0;
   logic [LANES*16-1:0] src_lanes = '0;
   logic [LANES*16-1:0] dst_lanes;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   h2i_conv #(.LANES(LANES)) i_h2i_conv (
      .clk(clk), .rst_n(rst_n), .dst_kind(dst_kind), .insn_sat(insn_sat),
      .ctrl_word(ctrl_word), .rnd_mode(rnd_mode), .lane_en(lane_en),
      .src_lanes(src_lanes), .dst_lanes(dst_lanes)
   );

   // {req, src, kind, sat, rnd, expected}
   localparam logic [41:0] VEC [NV] = '{
      {4'd3,  16'h4100, 2'd3, 1'b1, 3'd0, 16'h0002}, // R3 2.5
      {4'd3,  16'h4300, 2'd3, 1'b1, 3'd0, 16'h0004}, // R3 3.5
      {4'd3,  16'hC100, 2'd3, 1'b1, 3'd0, 16'hFFFE}, // R3 -2.5
      {4'd3,  16'h3800, 2'd3, 1'b1, 3'd0, 16'h0000}, // R3 0.5
      {4'd4,  16'h4100, 2'd3, 1'b1, 3'd1, 16'h0003}, // R4
      {4'd4,  16'hC100, 2'd3, 1'b1, 3'd1, 16'hFFFD}, // R4
      {4'd4,  16'h3800, 2'd3, 1'b1, 3'd1, 16'h0001}, // R4
      {4'd5,  16'hBE00, 2'd3, 1'b1, 3'd2, 16'hFFFE}, // R5 floor -1.5
      {4'd5,  16'hBE00, 2'd3, 1'b1, 3'd3, 16'hFFFF}, // R5 ceil -1.5
      {4'd5,  16'h0001, 2'd3, 1'b1, 3'd3, 16'h0001}, // R5 subnormal ceil
      {4'd5,  16'h8001, 2'd3, 1'b1, 3'd2, 16'hFFFF}, // R5 subnormal floor
      {4'd5,  16'h0001, 2'd3, 1'b1, 3'd2, 16'h0000}, // R5
      {4'd6,  16'h4180, 2'd3, 1'b1, 3'd4, 16'h0002}, // R6
      {4'd6,  16'hC180, 2'd3, 1'b1, 3'd4, 16'hFFFE}, // R6
      {4'd6,  16'hC180, 2'd3, 1'b1, 3'd7, 16'hFFFE}, // R6 code 7
      {4'd7,  16'h5C04, 2'd0, 1'b0, 3'd0, 16'h0001}, // R7 257 u8
      {4'd7,  16'h5CB0, 2'd1, 1'b0, 3'd0, 16'h002C}, // R7 300 s8
      {4'd7,  16'hBC00, 2'd0, 1'b0, 3'd0, 16'h00FF}, // R7 -1 u8
      {4'd7,  16'hDA40, 2'd1, 1'b0, 3'd0, 16'h0038}, // R7 -200 s8
      {4'd7,  16'h7BFF, 2'd2, 1'b0, 3'd0, 16'hFFE0}, // R7 65504 u16
      {4'd8,  16'h5C04, 2'd0, 1'b1, 3'd0, 16'h00FF}, // R8
      {4'd8,  16'h5A40, 2'd1, 1'b1, 3'd0, 16'h007F}, // R8
      {4'd8,  16'hDA40, 2'd1, 1'b1, 3'd0, 16'h0080}, // R8
      {4'd8,  16'h7BFF, 2'd3, 1'b1, 3'd0, 16'h7FFF}, // R8
      {4'd8,  16'hC500, 2'd2, 1'b1, 3'd0, 16'h0000}, // R8
      {4'd9,  16'h7C00, 2'd0, 1'b0, 3'd0, 16'h00FF}, // R9
      {4'd9,  16'hFC00, 2'd0, 1'b0, 3'd0, 16'h0000}, // R9
      {4'd9,  16'hFC00, 2'd3, 1'b0, 3'd0, 16'h8000}, // R9
      {4'd9,  16'h7C00, 2'd1, 1'b1, 3'd0, 16'h007F}, // R9
      {4'd9,  16'hFC00, 2'd1, 1'b1, 3'd0, 16'h0080}, // R9
      {4'd10, 16'h7E00, 2'd3, 1'b1, 3'd0, 16'h0000}, // R10
      {4'd10, 16'hFE01, 2'd0, 1'b0, 3'd0, 16'h0000}, // R10
      {4'd12, 16'h5CB0, 2'd3, 1'b0, 3'd0, 16'h012C}, // R12 300 s16
      {4'd12, 16'h5CB0, 2'd0, 1'b1, 3'd0, 16'h00FF}  // R12 300 u8
   };

   task automatic check(input string req, input logic [LANES*16-1:0] act,
                        input logic [LANES*16-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] src, input logic [1:0] kind,
                        input logic sat, input logic [2:0] rnd,
                        input logic [63:0] ctrl, input logic [LANES-1:0] en);
      @(negedge clk);
      src_lanes = {LANES{src}};
      dst_kind  = kind;
      insn_sat  = sat;
      rnd_mode  = rnd;
      ctrl_word = ctrl;
      lane_en   = en;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 reset", dst_lanes, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][37:22], VEC[i][21:20], VEC[i][19], VEC[i][18:16],
               64'd0, {LANES{1'b1}});
         check($sformatf("R%0d vec%0d", VEC[i][41:38], i), dst_lanes,
               {LANES{VEC[i][15:0]}});
      end

      // R11 global override: non-saturating despite insn_sat=1
      apply(16'h5C04, 2'd0, 1'b1, 3'd0, 64'h1800_0000_0000_0000, {LANES{1'b1}});
      check("R11 global nosat", dst_lanes, {LANES{16'h0001}});
      // R11 global override: saturating despite insn_sat=0
      apply(16'h5C04, 2'd0, 1'b0, 3'd0, 64'h1000_0000_0000_0000, {LANES{1'b1}});
      check("R11 global sat", dst_lanes, {LANES{16'h00FF}});
      // R11 bit 59 ignored when bit 60 clear
      apply(16'h5C04, 2'd0, 1'b0, 3'd0, 64'h0800_0000_0000_0000, {LANES{1'b1}});
      check("R11 local flag", dst_lanes, {LANES{16'h00FF}} & '0 | {LANES{16'h0001}});

      // R2 lane enable
      apply(16'h4500, 2'd3, 1'b1, 3'd0, 64'd0, 4'b0101);
      check("R2 masked lanes", dst_lanes, {16'h0000, 16'h0005, 16'h0000, 16'h0005});
      apply(16'h7C00, 2'd3, 1'b1, 3'd0, 64'd0, 4'b0000);
      check("R2 all masked", dst_lanes, '0);

      // R1 latency: output holds old result until the next edge
      apply(16'h4500, 2'd3, 1'b1, 3'd0, 64'd0, {LANES{1'b1}});
      src_lanes = {LANES{16'h4600}};
      #1;
      check("R1 latency hold", dst_lanes, {LANES{16'h0005}});
      @(negedge clk);
      check("R1 latency update", dst_lanes, {LANES{16'h0006}});

      // R1 asynchronous reset clears the outputs
      rst_n = 1'b0;
      #1;
      check("R1 reset mid-run", dst_lanes, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", dst_lanes, {LANES{16'h0006}});

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule